// File: doc/BRIEF.md
# Manchester Word Encoder

This encoder turns one serially presented data word into a Manchester-coded line frame. The frame starts with a three-bit-time synchronizing character, then carries the data bits most significant first, and ends with one parity bit. The line is driven through two active-low outputs. One output asserts for the positive line state and the other for the negative line state. Both outputs rest high whenever no frame is on the line.

The encoder clock runs at twice the bit rate, so each clock cycle is one half of a bit cell. A divide-by-2 stage marks bit-cell boundaries, and a frame only starts on such a boundary. A separate divide-by-6 output is derived from the same clock. An external source supplies the data in NRZ form. The encoder raises a shift clock once per data bit and captures the serial input on each rising edge of that clock. A sync-type input picks a command-type or a data-type character; it is captured when the frame starts. A line-inhibit input forces both line outputs idle without stopping the frame's timing. A master reset clears the dividers and abandons any frame in progress.

Top module: `mwe_encoder`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it is raised, `lineOneN` and `lineZeroN` are high, `shiftClk` is low and `divOut` is low. Releasing reset restarts both dividers from zero.
- R2: After n clock edges counted from reset release, `divOut` is high exactly when n mod 6 is 3, 4 or 5.
- R3: Suppose `encEnable` is high while the encoder is idle. The first half of the sync character then appears after an even edge count n, counted from reset release. It appears one or two edges after the edge that first samples the enable.
- R4: Each half cycle of the frame is either positive (`lineOneN`=0, `lineZeroN`=1) or negative (`lineOneN`=1, `lineZeroN`=0). With `cmdSync`=1 the sync character is 3 positive halves followed by 3 negative halves; with `cmdSync`=0 it is 3 negative halves followed by 3 positive halves.
- R5: Half cycles 6 to 37 carry 16 data bits, most significant first. A 1 is a positive half followed by a negative half; a 0 is the reverse.
- R6: Half cycles 38 and 39 carry a parity bit, encoded as in R5. Its value makes the count of ones across the 16 data bits and the parity bit odd.
- R7: `shiftClk` is high for exactly one cycle in half cycles 5, 7, 9, ..., 35 and low at all other times. The `serialIn` value sampled at the k-th rising edge of `shiftClk` is data bit 15-k.
- R8: While `outInhibitN` is low, both line outputs are high. The frame keeps its timing, so halves sent after inhibit is released match R4 to R6.
- R9: Both line outputs are high between frames. If `encEnable` stays high, the next frame begins after exactly two idle half cycles.
- R10: Changes on `cmdSync` after a frame has started do not affect that frame.
- R11: While `encEnable` is low and no frame is running, no frame starts and the line stays idle.
- R12: Raising `rst` during a frame returns both line outputs high after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encoder clock, two cycles per bit |
| rst | input | 1 | Master reset, active high |
| encEnable | input | 1 | Requests the start of a frame |
| cmdSync | input | 1 | 1 selects command-type sync, 0 selects data-type sync |
| serialIn | input | 1 | NRZ data, sampled on the rising edge of shiftClk |
| outInhibitN | input | 1 | Low forces both line outputs high |
| shiftClk | output | 1 | One pulse per data bit for the external data source |
| divOut | output | 1 | Encoder clock divided by 6 |
| lineOneN | output | 1 | Active-low positive line-state drive |
| lineZeroN | output | 1 | Active-low negative line-state drive |

## Verification
The bench fills `serialIn` with random values at every instant except the half cycle just before each shift pulse. A design that sampled off the pulse, or that let a fresh sample overwrite the bit still on the line during its second half, would therefore send corrupted data bits. All-zero, all-one and edge-bit words test the parity sense and the bit order, where an even-parity or LSB-first design would show up at once. The bench checks the alignment of frame starts against the bench's own edge count, which catches a start off the bit boundary. It runs back-to-back frames with the enable held high, which catches a missing idle gap. It also toggles the sync select and pulses inhibit in the middle of frames, and applies reset mid-frame; a design that re-read the select or paused under inhibit shows up as wrong later halves.

// File: rtl/mwe_pkg.sv
package mwe_pkg;

  // Strobes from the sequencer to the datapath, valid for the current half cycle.
  typedef struct packed {
    logic active;     // a frame occupies the line
    logic startWord;  // this edge begins a frame
    logic sampleBit;  // this edge captures serialIn
    logic loadData;   // this edge moves the captured bit onto the line
    logic loadParity; // this edge moves the parity bit onto the line
    logic inSync;     // current half belongs to the sync character
    logic syncLead;   // current half is in the leading part of sync
    logic firstHalf;  // current half is the first half of a bit cell
  } encStrobe_t;

endpackage

// File: rtl/mwe_clkdiv.sv
module mwe_clkdiv #(
  parameter int DIV_RATIO = 6
) (
  input  logic clk,
  input  logic rst,
  output logic halfPhase,
  output logic divOut
);

  localparam int DIV_W = $clog2(DIV_RATIO);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_RATIO - 1);
  localparam logic [DIV_W-1:0] DIV_HIGH = DIV_W'(DIV_RATIO / 2);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divNext;

  always_comb begin
    if (divCnt == DIV_LAST) divNext = '0;
    else                    divNext = divCnt + 1'b1;
  end

  // Divide-by-2: marks bit-cell boundaries (phase 0 = first half of a cell).
  always_ff @(posedge clk) begin
    if (rst) halfPhase <= 1'b0;
    else     halfPhase <= ~halfPhase;
  end

  // Divide-by-N: output high for the upper half of the count.
  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= '0;
      divOut <= 1'b0;
    end else begin
      divCnt <= divNext;
      divOut <= (divNext >= DIV_HIGH);
    end
  end

endmodule

// File: rtl/mwe_ctrl.sv
module mwe_ctrl
  import mwe_pkg::*;
#(
  parameter int DATA_BITS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       encEnable,
  input  logic       halfPhase,
  output encStrobe_t strobe,
  output logic       shiftClk
);

  localparam int SYNC_HALVES = 6;
  localparam int WORD_HALVES = SYNC_HALVES + 2 * DATA_BITS + 2;
  localparam int CNT_W       = $clog2(WORD_HALVES);

  localparam logic [CNT_W-1:0] LAST_HALF   = CNT_W'(WORD_HALVES - 1);
  localparam logic [CNT_W-1:0] SYNC_END    = CNT_W'(SYNC_HALVES);
  localparam logic [CNT_W-1:0] LEAD_END    = CNT_W'(SYNC_HALVES / 2);
  localparam logic [CNT_W-1:0] SAMPLE_LO   = CNT_W'(SYNC_HALVES - 2);
  localparam logic [CNT_W-1:0] SAMPLE_HI   = CNT_W'(SYNC_HALVES - 2 + 2 * (DATA_BITS - 1));
  localparam logic [CNT_W-1:0] LOAD_LO     = CNT_W'(SYNC_HALVES - 1);
  localparam logic [CNT_W-1:0] LOAD_HI     = CNT_W'(SYNC_HALVES - 1 + 2 * (DATA_BITS - 1));
  localparam logic [CNT_W-1:0] PARITY_LOAD = CNT_W'(WORD_HALVES - 3);

  logic             busy;
  logic [CNT_W-1:0] halfCnt;
  logic             lastHalf;

  always_comb begin
    lastHalf          = busy && (halfCnt == LAST_HALF);
    strobe.active     = busy;
    // Frames begin only at the edge that opens a new bit cell.
    strobe.startWord  = !busy && encEnable && halfPhase;
    strobe.inSync     = halfCnt < SYNC_END;
    strobe.syncLead   = halfCnt < LEAD_END;
    strobe.firstHalf  = ~halfCnt[0];
    // Capture one half ahead of each data bit, at the end of an even half.
    strobe.sampleBit  = busy && ~halfCnt[0] &&
                        (halfCnt >= SAMPLE_LO) && (halfCnt <= SAMPLE_HI);
    strobe.loadData   = busy && halfCnt[0] &&
                        (halfCnt >= LOAD_LO) && (halfCnt <= LOAD_HI);
    strobe.loadParity = busy && (halfCnt == PARITY_LOAD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      halfCnt  <= '0;
      shiftClk <= 1'b0;
    end else begin
      shiftClk <= strobe.sampleBit;
      if (strobe.startWord) begin
        busy    <= 1'b1;
        halfCnt <= '0;
      end else if (lastHalf) begin
        busy    <= 1'b0;
        halfCnt <= '0;
      end else if (busy) begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mwe_datapath.sv
module mwe_datapath
  import mwe_pkg::*;
#(
  parameter bit ODD_PARITY = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  encStrobe_t strobe,
  input  logic       cmdSync,
  input  logic       serialIn,
  input  logic       outInhibitN,
  output logic       lineOneN,
  output logic       lineZeroN
);

  logic syncSelReg;  // sync type held for the whole frame
  logic holdBit;     // bit captured from serialIn, waiting for its cell
  logic curBit;      // bit currently on the line
  logic parAcc;      // running XOR of captured data bits
  logic parityBit;
  logic positive;
  logic drive;

  generate
    if (ODD_PARITY) begin : g_odd
      assign parityBit = ~parAcc;
    end else begin : g_even
      assign parityBit = parAcc;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      syncSelReg <= 1'b0;
      holdBit    <= 1'b0;
      curBit     <= 1'b0;
      parAcc     <= 1'b0;
    end else begin
      if (strobe.startWord) begin
        syncSelReg <= cmdSync;
        parAcc     <= 1'b0;
      end
      if (strobe.sampleBit) begin
        holdBit <= serialIn;
        parAcc  <= parAcc ^ serialIn;
      end
      if (strobe.loadData)        curBit <= holdBit;
      else if (strobe.loadParity) curBit <= parityBit;
    end
  end

  always_comb begin
    if (strobe.inSync) positive = syncSelReg ? strobe.syncLead : ~strobe.syncLead;
    else               positive = curBit ? strobe.firstHalf : ~strobe.firstHalf;
    drive     = strobe.active && outInhibitN;
    lineOneN  = ~(drive && positive);
    lineZeroN = ~(drive && ~positive);
  end

endmodule

// File: rtl/mwe_encoder.sv
module mwe_encoder
  import mwe_pkg::*;
#(
  parameter int DATA_BITS  = 16,
  parameter int DIV_RATIO  = 6,
  parameter bit ODD_PARITY = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic encEnable,
  input  logic cmdSync,
  input  logic serialIn,
  input  logic outInhibitN,
  output logic shiftClk,
  output logic divOut,
  output logic lineOneN,
  output logic lineZeroN
);

  encStrobe_t strobe;
  logic       halfPhase;

  mwe_clkdiv #(.DIV_RATIO(DIV_RATIO)) u_clkdiv (
    .clk       (clk),
    .rst       (rst),
    .halfPhase (halfPhase),
    .divOut    (divOut)
  );

  mwe_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .encEnable (encEnable),
    .halfPhase (halfPhase),
    .strobe    (strobe),
    .shiftClk  (shiftClk)
  );

  mwe_datapath #(.ODD_PARITY(ODD_PARITY)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .cmdSync     (cmdSync),
    .serialIn    (serialIn),
    .outInhibitN (outInhibitN),
    .lineOneN    (lineOneN),
    .lineZeroN   (lineZeroN)
  );

endmodule

// File: rtl/mwe_encoder_chk.sv
module mwe_encoder_chk (
  input logic clk,
  input logic rst,
  input logic outInhibitN,
  input logic lineOneN,
  input logic lineZeroN,
  input logic shiftClk,
  input logic divOut,
  input logic active
);

  // R4
  lines_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    lineOneN || lineZeroN);

  // R8
  inhibit_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !outInhibitN |-> (lineOneN && lineZeroN));

  // R9
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    !active |-> (lineOneN && lineZeroN));

  // R7
  shift_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    shiftClk |=> !shiftClk);

  // R7
  shift_in_word_chk: assert property (@(posedge clk) disable iff (rst)
    shiftClk |-> active);

  // R2
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(divOut) |=> divOut);

endmodule

bind mwe_encoder mwe_encoder_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .outInhibitN (outInhibitN),
  .lineOneN    (lineOneN),
  .lineZeroN   (lineZeroN),
  .shiftClk    (shiftClk),
  .divOut      (divOut),
  .active      (strobe.active)
);

// File: tb/mwe_encoder_bench.sv
module mwe_encoder_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic encEnable = 1'b0;
  logic cmdSync = 1'b0;
  logic serialIn = 1'b0;
  logic outInhibitN = 1'b1;
  logic shiftClk, divOut, lineOneN, lineZeroN;

  int checks = 0;
  int fails = 0;
  int edgeCnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) edgeCnt <= 0;
    else     edgeCnt <= edgeCnt + 1;
  end

  mwe_encoder u_mwe_encoder (
    .clk(clk), .rst(rst), .encEnable(encEnable), .cmdSync(cmdSync),
    .serialIn(serialIn), .outInhibitN(outInhibitN), .shiftClk(shiftClk),
    .divOut(divOut), .lineOneN(lineOneN), .lineZeroN(lineZeroN)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Positive line state for half h of a frame carrying d with sync select sel.
  function automatic bit expPos(int h, logic [15:0] d, bit sel);
    bit lead, b, first;
    if (h < 6) begin
      lead = (h < 3);
      return sel ? lead : !lead;
    end
    first = (h % 2 == 0);
    if (h < 38) b = d[15 - (h - 6) / 2];
    else        b = ~^d;
    return b ? first : !first;
  endfunction

  // {lineOneN, lineZeroN} expected for half h.
  function automatic logic [1:0] expLines(int h, logic [15:0] d, bit sel, bit inh);
    if (inh) return 2'b11;
    return expPos(h, d, sel) ? 2'b01 : 2'b10;
  endfunction

  function automatic bit expShift(int h);
    return (h >= 5) && (h <= 35) && (h % 2 == 1);
  endfunction

  task automatic runWord(input logic [15:0] d, input bit sel, input int inhPct,
                         input bit keepEn, input bit flipSel);
    int e;
    int t;
    string tag;
    @(negedge clk);
    cmdSync   = sel;
    encEnable = 1'b1;
    e = edgeCnt;
    t = 0;
    do begin
      @(negedge clk);
      t++;
      serialIn = 1'($urandom);
    end while ((lineOneN && lineZeroN) && t < 6);
    // R3
    chk((edgeCnt % 2 == 0) && (edgeCnt - e >= 1) && (edgeCnt - e <= 2),
        "R3 start alignment", 32'(edgeCnt - e), 32'(2));
    if (!keepEn) encEnable = 1'b0;
    for (int h = 0; h < 40; h++) begin
      bit inh;
      if (h > 0) @(negedge clk);
      inh = (h > 0) && (($urandom % 100) < 32'(inhPct));
      outInhibitN = !inh;
      #1;
      if (inh)          tag = "R8 inhibit";
      else if (h < 6)   tag = flipSel ? "R4 R10 sync" : "R4 sync";
      else if (h < 38)  tag = flipSel ? "R5 R10 data" : "R5 data";
      else              tag = "R6 parity";
      chk({lineOneN, lineZeroN} == expLines(h, d, sel, inh), tag,
          32'({lineOneN, lineZeroN}), 32'(expLines(h, d, sel, inh)));
      chk(shiftClk == expShift(h), "R7 shift clock", 32'(shiftClk), 32'(expShift(h)));
      if (flipSel) cmdSync = 1'($urandom);
      if ((h % 2 == 0) && (h >= 4) && (h <= 34)) serialIn = d[15 - (h - 4) / 2];
      else                                       serialIn = 1'($urandom);
    end
    outInhibitN = 1'b1;
  endtask

  task automatic checkDiv(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      // R2
      chk(divOut == ((edgeCnt % 6) >= 3), "R2 divide by 6", 32'(divOut),
          32'((edgeCnt % 6) >= 3));
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1
    chk(lineOneN && lineZeroN, "R1 reset lines", 32'({lineOneN, lineZeroN}), 32'(3));
    chk(!shiftClk && !divOut, "R1 reset clocks", 32'({shiftClk, divOut}), 32'(0));
    rst = 1'b0;
    checkDiv(14);

    // R11
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(lineOneN && lineZeroN, "R11 no start without enable",
          32'({lineOneN, lineZeroN}), 32'(3));
    end

    runWord(16'h0000, 1'b1, 0, 1'b0, 1'b0);
    runWord(16'hFFFF, 1'b0, 0, 1'b0, 1'b0);
    runWord(16'h8001, 1'b1, 0, 1'b0, 1'b0);
    runWord(16'h7FFE, 1'b0, 0, 1'b0, 1'b1);
    runWord(16'hA5C3, 1'b1, 50, 1'b0, 1'b0);

    // R9: back-to-back frames with enable held
    runWord(16'h1234, 1'b0, 0, 1'b1, 1'b0);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(lineOneN && lineZeroN, "R9 idle gap", 32'({lineOneN, lineZeroN}), 32'(3));
    end
    @(negedge clk);
    chk({lineOneN, lineZeroN} == 2'b10, "R9 next frame starts",
        32'({lineOneN, lineZeroN}), 32'(2));

    // R12: reset in the middle of a frame
    repeat (7) @(negedge clk);
    encEnable = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk(lineOneN && lineZeroN, "R12 abort lines", 32'({lineOneN, lineZeroN}), 32'(3));
    chk(!shiftClk && !divOut, "R1 R12 abort clocks", 32'({shiftClk, divOut}), 32'(0));
    @(negedge clk);
    rst = 1'b0;
    checkDiv(8);

    for (int w = 0; w < 20; w++) begin
      runWord(16'($urandom), 1'($urandom), 10, 1'b0, 1'b1);
    end

    // R11 after frames
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(lineOneN && lineZeroN, "R11 idle after frames",
          32'({lineOneN, lineZeroN}), 32'(3));
    end
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

endmodule